// File: doc/BRIEF.md
# Flash Access Protection Checker

This block stands between an access initiator and a flash array and decides, request by request, whether the access may go ahead. It combines three inputs to reach that decision. The first is a read-protection byte, which selects one of three protection levels. The second is a write-protection mask, with one bit for each group of four pages. The third is the context the processor is running in: normal user boot, debug, boot from SRAM, or boot from system memory. Each accepted request gets exactly one answer one cycle later, either a grant pulse or a deny pulse. A denied request produces no operation.

The block also handles requests to rewrite the protection byte. Going back from the guarded level to the open level is only allowed once the whole main array has been wiped. For that case the block starts a mass erase, raises a busy flag and refuses to accept new requests until the flash reports that the erase has finished. Only then does it release the new byte for writing. The protection byte and the mask are loaded from option storage at reset. Here they are plain inputs, and the flash cell timing is left to the array controller.

Top module: `flash_guard`

## Requirements
- R1: The protection byte maps to a level. 0xAA is the open level, 0xCC is the sealed level, and every other value is the guarded level.
- R2: At the open level, read (op 0), program (op 1) and erase (op 2) are granted on the main array (area 0) and on the option area (area 1), unless R6 applies.
- R3: At the guarded level in the user context (ctx 0), both areas are fully accessible, unless R6 applies.
- R4: At the guarded level in the debug (ctx 1), SRAM-boot (ctx 2) or system-memory-boot (ctx 3) context, every main-array request is denied and every option-area request is granted.
- R5: At the sealed level, every request is denied in every context, including a level-write request (op 3).
- R6: The group index of a page is the page address shifted right by 2, saturating at 31. A mask bit of 0 protects its group. Program or erase on a protected main-array page is denied at every level. Reads are not affected, and neither is the option area.
- R7: A request is accepted on a clock edge where reqValid and reqReady are both high. Exactly one of grant and deny pulses for one cycle in the next cycle.
- R8: A level-write request (op 3, area ignored) at the open or guarded level is granted at once, unless R9 applies. It pulses rdpWrite together with grant, and rdpWrData carries the requested byte.
- R9: A level-write of 0xAA at the guarded level pulses massErase and raises busy in the next cycle. busy stays high until eraseDone is sampled. In the cycle after that, busy is low and grant and rdpWrite pulse with rdpWrData equal to 0xAA.
- R10: While busy is high, reqReady is low and requests produce no grant or deny. eraseDone is ignored while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdpByte | input | 8 | Current read-protection byte |
| wrpMask | input | 32 | Write-protection mask, one bit per group, 0 = protected |
| ctx | input | 2 | Execution context: 0 user, 1 debug, 2 SRAM boot, 3 system memory boot |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqOp | input | 2 | 0 read, 1 program, 2 erase, 3 level write |
| reqArea | input | 1 | 0 main array, 1 option area |
| reqPage | input | 10 | Page address |
| reqData | input | 8 | New protection byte for a level write |
| eraseDone | input | 1 | Flash reports the mass erase finished |
| grant | output | 1 | One-cycle grant pulse |
| deny | output | 1 | One-cycle deny pulse |
| busy | output | 1 | Forced mass erase in progress |
| massErase | output | 1 | One-cycle start pulse for the mass erase |
| rdpWrite | output | 1 | One-cycle pulse to write the protection byte |
| rdpWrData | output | 8 | Protection byte to write |

## Verification
The hardest situation to reach is the forced-erase window. It needs a guarded-level protection byte, a level write of exactly 0xAA, and then a stretch where requests keep arriving and are not answered while the erase is pending. The stimulus first pulses eraseDone while the block is idle, to show that the pulse has no effect. It then issues the lowering request from the debug context, holds a read request on the inputs for several cycles of busy, and releases eraseDone. A behavioural model compares grant, deny, busy, reqReady, massErase, rdpWrite and the written byte on every clock, across a sweep of every level, context, operation, area and chosen page, including pages past the last group.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN   = 2'd0,
    LVL_GUARD  = 2'd1,
    LVL_SEALED = 2'd2
  } level_e;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_ERASE  = 2'd2,
    OP_SETLVL = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CTX_USER   = 2'd0,
    CTX_DEBUG  = 2'd1,
    CTX_SRAM   = 2'd2,
    CTX_SYSMEM = 2'd3
  } ctx_e;

  // datapath -> control: policy outcome for the presented request
  typedef struct packed {
    logic allow;
    logic needErase;
    logic sealed;
  } verdict_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadData;
  } strobe_t;

endpackage

// File: rtl/fg_path.sv
module fg_path
  import flash_guard_pkg::*;
#(
  parameter int PAGE_W      = 10,
  parameter int GROUP_PAGES = 4,
  parameter int GROUPS      = 32,
  parameter logic [7:0] OPEN_BYTE   = 8'hAA,
  parameter logic [7:0] SEALED_BYTE = 8'hCC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rdpByte,
  input  logic [GROUPS-1:0] wrpMask,
  input  logic [1:0]        ctx,
  input  logic [1:0]        reqOp,
  input  logic              reqArea,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [7:0]        reqData,
  input  strobe_t           strobe,
  output verdict_t          verdict,
  output logic [7:0]        rdpWrData
);

  localparam int SHIFT  = $clog2(GROUP_PAGES);
  localparam int GIDX_W = $clog2(GROUPS);
  localparam int RAW_W  = PAGE_W - SHIFT;

  level_e level;
  logic [RAW_W-1:0]  grpRaw;
  logic [GIDX_W-1:0] gIdx;
  logic mainBlocked, wrBlocked, isWriteOp;

  always_comb begin
    if (rdpByte == OPEN_BYTE)        level = LVL_OPEN;
    else if (rdpByte == SEALED_BYTE) level = LVL_SEALED;
    else                             level = LVL_GUARD;
  end

  assign grpRaw = reqPage[PAGE_W-1:SHIFT];

  generate
    if (RAW_W > GIDX_W) begin : g_sat
      always_comb begin
        if (grpRaw > RAW_W'(GROUPS - 1)) gIdx = GIDX_W'(GROUPS - 1);
        else                             gIdx = grpRaw[GIDX_W-1:0];
      end
    end else begin : g_fit
      assign gIdx = GIDX_W'(grpRaw);
    end
  endgenerate

  assign isWriteOp   = (reqOp == OP_PROG) || (reqOp == OP_ERASE);
  assign mainBlocked = !reqArea && (level == LVL_GUARD) && (ctx != CTX_USER);
  assign wrBlocked   = !reqArea && isWriteOp && !wrpMask[gIdx];

  always_comb begin
    verdict.sealed    = (level == LVL_SEALED);
    verdict.allow     = !verdict.sealed &&
                        ((reqOp == OP_SETLVL) || (!mainBlocked && !wrBlocked));
    verdict.needErase = (reqOp == OP_SETLVL) && (level == LVL_GUARD) &&
                        (reqData == OPEN_BYTE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdpWrData <= '0;
    else if (strobe.loadData) rdpWrData <= reqData;
  end

  // the byte held for a level write is the one presented when it was accepted
  assert_wrdata_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadData |=> (rdpWrData == $past(reqData)));

endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import flash_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       eraseDone,
  input  verdict_t   verdict,
  output strobe_t    strobe,
  output logic       reqReady,
  output logic       grant,
  output logic       deny,
  output logic       busy,
  output logic       massErase,
  output logic       rdpWrite
);

  typedef enum logic {ST_IDLE, ST_ERASE} state_e;
  state_e state;
  logic accept;

  assign busy     = (state == ST_ERASE);
  assign reqReady = !busy;
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobe.loadData = accept && verdict.allow && (reqOp == OP_SETLVL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      grant     <= 1'b0;
      deny      <= 1'b0;
      massErase <= 1'b0;
      rdpWrite  <= 1'b0;
    end else begin
      grant     <= 1'b0;
      deny      <= 1'b0;
      massErase <= 1'b0;
      rdpWrite  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!verdict.allow) begin
              deny <= 1'b1;
            end else if (verdict.needErase) begin
              state     <= ST_ERASE;
              massErase <= 1'b1;
            end else begin
              grant    <= 1'b1;
              rdpWrite <= (reqOp == OP_SETLVL);
            end
          end
        end
        ST_ERASE: begin
          if (eraseDone) begin
            state    <= ST_IDLE;
            grant    <= 1'b1;
            rdpWrite <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_one_response_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && deny));

  assert_sealed_denied_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && verdict.sealed) |=> deny);

  assert_erase_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    massErase |-> busy);

  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !eraseDone) |=> busy);

  assert_finish_grant_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && eraseDone) |=> (grant && rdpWrite && !busy));

  assert_busy_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!grant && !deny && !rdpWrite && !reqReady));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int PAGE_W      = 10,
  parameter int GROUP_PAGES = 4,
  parameter int GROUPS      = 32,
  parameter logic [7:0] OPEN_BYTE   = 8'hAA,
  parameter logic [7:0] SEALED_BYTE = 8'hCC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rdpByte,
  input  logic [GROUPS-1:0] wrpMask,
  input  logic [1:0]        ctx,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic              reqArea,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [7:0]        reqData,
  input  logic              eraseDone,
  output logic              grant,
  output logic              deny,
  output logic              busy,
  output logic              massErase,
  output logic              rdpWrite,
  output logic [7:0]        rdpWrData
);

  verdict_t verdict;
  strobe_t  strobe;

  fg_path #(
    .PAGE_W(PAGE_W), .GROUP_PAGES(GROUP_PAGES), .GROUPS(GROUPS),
    .OPEN_BYTE(OPEN_BYTE), .SEALED_BYTE(SEALED_BYTE)
  ) u_path (
    .clk(clk), .rstN(rstN), .rdpByte(rdpByte), .wrpMask(wrpMask), .ctx(ctx),
    .reqOp(reqOp), .reqArea(reqArea), .reqPage(reqPage), .reqData(reqData),
    .strobe(strobe), .verdict(verdict), .rdpWrData(rdpWrData)
  );

  fg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .eraseDone(eraseDone), .verdict(verdict), .strobe(strobe),
    .reqReady(reqReady), .grant(grant), .deny(deny), .busy(busy),
    .massErase(massErase), .rdpWrite(rdpWrite)
  );

endmodule

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] rdpByte = 8'hAA;
  logic [31:0] wrpMask = 32'h7FFF_FFF5;  // groups 1, 3, 31 protected
  logic [1:0] ctx = 2'd0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic reqArea = 1'b0;
  logic [9:0] reqPage = '0;
  logic [7:0] reqData = '0;
  logic eraseDone = 1'b0;
  logic reqReady, grant, deny, busy, massErase, rdpWrite;
  logic [7:0] rdpWrData;

  always #2.5 clk = ~clk;

  flash_guard u_dut (
    .clk(clk), .rstN(rstN), .rdpByte(rdpByte), .wrpMask(wrpMask), .ctx(ctx),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqArea(reqArea),
    .reqPage(reqPage), .reqData(reqData), .eraseDone(eraseDone),
    .grant(grant), .deny(deny), .busy(busy), .massErase(massErase),
    .rdpWrite(rdpWrite), .rdpWrData(rdpWrData)
  );

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  string curTag = "R7";

  // ---------------- behavioural reference ----------------
  bit mBusy, eG, eD, eM, eW;
  logic [7:0] eData;

  function automatic int levelOf(logic [7:0] b);
    if (b == 8'hAA) return 0;
    if (b == 8'hCC) return 2;
    return 1;
  endfunction

  function automatic bit permitted(logic [7:0] b, int c, int op, int area, int page, logic [31:0] m);
    int lv = levelOf(b);
    int grp;
    if (lv == 2) return 0;
    if (op == 3) return 1;
    if (area == 0) begin
      if (lv == 1 && c != 0) return 0;
      if (op == 1 || op == 2) begin
        grp = page / 4;
        if (grp > 31) grp = 31;
        if (m[grp] == 1'b0) return 0;
      end
    end
    return 1;
  endfunction

  always @(posedge clk) begin : model
    bit g, d, w, me;
    if (!rstN) begin
      mBusy <= 0; eG <= 0; eD <= 0; eM <= 0; eW <= 0; eData <= 8'h00;
    end else begin
      g = 0; d = 0; w = 0; me = 0;
      if (mBusy) begin
        if (eraseDone) begin
          mBusy <= 0; g = 1; w = 1;
        end
      end else if (reqValid) begin
        if (!permitted(rdpByte, ctx, reqOp, reqArea, reqPage, wrpMask)) d = 1;
        else if (reqOp == 3 && levelOf(rdpByte) == 1 && reqData == 8'hAA) begin
          mBusy <= 1; me = 1; eData <= reqData;
        end else begin
          g = 1;
          if (reqOp == 3) begin w = 1; eData <= reqData; end
        end
      end
      eG <= g; eD <= d; eW <= w; eM <= me;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string name, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", curTag, name, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("grant", {7'd0, grant}, {7'd0, eG});
    chk("deny", {7'd0, deny}, {7'd0, eD});
    chk("busy", {7'd0, busy}, {7'd0, mBusy});
    chk("reqReady", {7'd0, reqReady}, {7'd0, !mBusy});
    chk("massErase", {7'd0, massErase}, {7'd0, eM});
    chk("rdpWrite", {7'd0, rdpWrite}, {7'd0, eW});
    if (eW) chk("rdpWrData", rdpWrData, eData);
  endtask

  function automatic string tagFor(logic [7:0] b, int c, int op, int area, int page);
    int lv = levelOf(b);
    int grp = page / 4;
    if (grp > 31) grp = 31;
    if (lv == 2) return "R1,R5";
    if (lv == 1 && c != 0 && area == 0) return "R1,R4";
    if (area == 0 && (op == 1 || op == 2) && wrpMask[grp] == 1'b0) return "R6";
    if (lv == 1) return (c == 0) ? "R1,R3" : "R1,R4";
    return "R1,R2";
  endfunction

  task automatic request(logic [7:0] b, int c, int op, int area, int page, logic [7:0] data);
    rdpByte = b; ctx = 2'(c); reqOp = 2'(op); reqArea = area[0];
    reqPage = 10'(page); reqData = data; reqValid = 1'b1;
    tick();
    curTag = tagFor(b, c, op, area, page);
    reqValid = 1'b0;
    tick();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nFail++; nChecks++;
        $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
        $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] bytes [4] = '{8'hAA, 8'hCC, 8'h55, 8'h00};
    int pages [6] = '{0, 5, 13, 127, 1023, 8};
    // reset state
    curTag = "R7";
    tick(); tick();
    rstN = 1'b1;
    tick();

    // full policy sweep (R2..R6, R7)
    foreach (bytes[bi])
      for (int c = 0; c < 4; c++)
        for (int op = 0; op < 3; op++)
          for (int a = 0; a < 2; a++)
            foreach (pages[pi])
              request(bytes[bi], c, op, a, pages[pi], 8'h00);

    // back-to-back requests, one answer each (R7)
    curTag = "R7";
    rdpByte = 8'hAA; ctx = 0; reqArea = 0; reqValid = 1'b1;
    for (int k = 0; k < 6; k++) begin
      reqOp = 2'(k % 3); reqPage = 10'(k * 3);
      tick();
    end
    reqValid = 1'b0;
    tick();

    // immediate level writes (R8) and sealed refusal (R5)
    request(8'hAA, 0, 3, 1, 0, 8'h55); curTag = "R8"; tick();
    request(8'h12, 1, 3, 0, 0, 8'hCC); curTag = "R8"; tick();
    request(8'hAA, 2, 3, 1, 0, 8'hAA); curTag = "R8"; tick();
    request(8'hCC, 0, 3, 1, 0, 8'hAA); curTag = "R5"; tick();

    // eraseDone while idle has no effect (R10)
    curTag = "R10";
    eraseDone = 1'b1; tick(); eraseDone = 1'b0; tick();

    // forced erase on lowering the level (R9), stalling while busy (R10)
    curTag = "R9";
    rdpByte = 8'h12; ctx = 1; reqOp = 3; reqArea = 1; reqData = 8'hAA; reqValid = 1'b1;
    tick();
    curTag = "R10";
    reqOp = 0; reqArea = 1; reqData = 8'h00;  // read kept pending while busy
    for (int k = 0; k < 5; k++) tick();
    curTag = "R9";
    eraseDone = 1'b1;
    tick();
    eraseDone = 1'b0;
    reqValid = 1'b0;
    tick();
    tick();

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule